// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block turns one transfer request into the ordered series of bit-level commands an I2C master needs: an optional START, the slave address (7-bit or 10-bit form) with the direction bit, the data bytes with acknowledge handling, and an optional STOP. It does not drive the bus lines itself. A separate bit engine executes one command at a time (start, stop, write bit, read bit, abort-and-recover) and returns a response carrying the sampled bit and an error code. The sequencer waits for each response before it issues the next command.

A client presents a request with address, direction, byte count and three flags: 10-bit addressing, skip START and address, and skip STOP. Write data is pulled one byte at a time over a valid/ready handshake. Read data is delivered with a one-cycle strobe per byte. When a transfer ends, a one-cycle done pulse carries a status code. A transfer that leaves the bus held, with no STOP, makes the next START a repeated start. A following request with the skip-START flag set continues the same bus transaction.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and cmd_valid_o, wr_ready_o, rd_valid_o and done_o are 0.
- R2: A request of length 0 issues no bit command. In the cycle after acceptance it gives done_o with status 3 (invalid argument).
- R3: Command codes on cmd_o are start=0, stop=1, write bit=2, read bit=3, abort=4, and cmd_bit_o carries the written bit. A 7-bit request sends START and then the byte {addr[6:0], dir}, where dir is 1 for a read.
- R4: A 10-bit request sends two address bytes: {5'b11110, addr[9:8], dir}, then addr[7:0]. Each byte is followed by an acknowledge read.
- R5: Every byte goes out MSB first as 8 write-bit commands followed by one read-bit command. A low response bit means acknowledged. wr_ready_o is raised only when the next write byte is needed, and exactly one byte is taken per handshake.
- R6: A read issues 8 read-bit commands per byte. It then presents the byte, MSB first, on rd_data_o with a single-cycle rd_valid_o. Next it writes an acknowledge bit: 0 for every byte except the last, which gets 1.
- R7: A successful transfer ends with STOP unless the no-stop flag is set. Status is then 0.
- R8: The no-start flag skips both START and the address bytes, so the first command is a data bit.
- R9: START carries cmd_bit_o=1 (repeated start) when the previous transfer ended without STOP. It carries 0 after a STOP, an abort, an engine error or reset.
- R10: A NACK on an address byte issues the abort command and ends with status 1 (no device). A NACK on a write data byte issues abort and ends with status 2 (I/O error). No further write byte is taken after either.
- R11: An engine error ends the transfer at once, with no abort and no STOP. Error code 2'b01 (stretch timeout) gives status 4, and 2'b10 (arbitration lost) gives status 5.
- R12: At most one command is outstanding. cmd_valid_o is a single-cycle pulse, and no command is issued while the block is idle.
- R13: done_o is a single-cycle pulse, and req_ready_o is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Idle, request accepted |
| req_addr_i | input | 10 | Slave address |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_len_i | input | LEN_W | Byte count |
| req_addr10_i | input | 1 | Use 10-bit address form |
| req_nostart_i | input | 1 | Skip START and address |
| req_nostop_i | input | 1 | Skip STOP |
| wr_data_i | input | 8 | Write byte |
| wr_valid_i | input | 1 | Write byte available |
| wr_ready_o | output | 1 | Write byte taken this cycle if valid |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Received byte strobe |
| done_o | output | 1 | Transfer finished strobe |
| status_o | output | 3 | Completion status |
| cmd_valid_o | output | 1 | Bit command strobe |
| cmd_o | output | 3 | Bit command code |
| cmd_bit_o | output | 1 | Bit to write / repeated-start flag |
| rsp_valid_i | input | 1 | Bit engine response strobe |
| rsp_bit_i | input | 1 | Sampled bus bit |
| rsp_err_i | input | 2 | Bit engine error code |

## Verification
Checked on every cycle: the command pulse discipline and the quiet idle state (R12), the single-cycle done and read strobes together with ready on completion (R13, R6), and the zero-length rejection (R2). Only the bench scenarios can show the exact command sequences: address byte forms, MSB-first order, ACK/NACK on the last read byte, and repeated-start tracking across transfers. The same holds for the separation of address NACK from data NACK and for the way engine errors cut a transfer short. The bench models the bit engine as a recorder that answers read bits from a scripted stream, and it compares the recorded commands against sequences derived from the requirements.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    CMD_START = 3'd0,
    CMD_STOP  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_READ  = 3'd3,
    CMD_ABORT = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NODEV   = 3'd1,
    ST_IO      = 3'd2,
    ST_INVAL   = 3'd3,
    ST_TIMEOUT = 3'd4,
    ST_ARBLOST = 3'd5
  } status_e;
endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
  import i2c_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              ten_i,
  input  logic              idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [4:0] TEN_HDR = 5'b11110;

  always_comb begin
    if (!ten_i)      byte_o = {addr_i[6:0], rd_i};
    else if (!idx_i) byte_o = {TEN_HDR, addr_i[9:8], rd_i};
    else             byte_o = addr_i[7:0];
  end
endmodule

// File: rtl/i2c_seq_shift.sv
module i2c_seq_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         msb_o,
  output logic         last_o
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= load_val_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[W-2:0], bit_i};
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign data_o = sh_q;
  assign msb_o  = sh_q[W-1];
  assign last_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [9:0]       req_addr_i,
  input  logic             req_read_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             req_addr10_i,
  input  logic             req_nostart_i,
  input  logic             req_nostop_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic [2:0]       status_o,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_o,
  output logic             cmd_bit_o,
  input  logic             rsp_valid_i,
  input  logic             rsp_bit_i,
  input  logic [1:0]       rsp_err_i
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ABYTE, S_AACK, S_LOAD, S_DBIT, S_DACK, S_STOP, S_ABORT
  } state_e;

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  state_e            state_q;
  logic              pend_q, started_q, a_idx_q;
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, ten_q, nostop_q;
  status_e           abort_st_q, stat_q;
  logic              done_q, rd_valid_q;
  logic [BYTE_W-1:0] rd_data_q;

  logic              is_cmd, rsp_fire, eng_err, ok_fire, last_byte, addr_last;
  logic [BYTE_W-1:0] abyte, sh_data, sh_val;
  logic              sh_load, sh_shift, sh_msb, sh_last;
  cmd_e              cmd;
  logic              cmd_bit;

  i2c_seq_addr u_addr (
    .addr_i (addr_q),
    .rd_i   (rd_q),
    .ten_i  (ten_q),
    .idx_i  (state_q == S_AACK),
    .byte_o (abyte)
  );

  i2c_seq_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (sh_val),
    .shift_i    (sh_shift),
    .bit_i      (rsp_bit_i),
    .data_o     (sh_data),
    .msb_o      (sh_msb),
    .last_o     (sh_last)
  );

  assign rsp_fire  = rsp_valid_i && pend_q;
  assign eng_err   = rsp_fire && (rsp_err_i != 2'b00) && (state_q != S_ABORT);
  assign ok_fire   = rsp_fire && !eng_err;
  assign last_byte = (left_q == LEN_ONE);
  assign addr_last = !ten_q || a_idx_q;

  // command decode
  always_comb begin
    is_cmd  = 1'b1;
    cmd     = CMD_WRITE;
    cmd_bit = 1'b0;
    unique case (state_q)
      S_START: begin cmd = CMD_START; cmd_bit = started_q; end
      S_ABYTE: cmd_bit = sh_msb;
      S_AACK:  cmd = CMD_READ;
      S_DBIT:  if (rd_q) cmd = CMD_READ; else cmd_bit = sh_msb;
      S_DACK:  if (rd_q) cmd_bit = last_byte; else cmd = CMD_READ;
      S_STOP:  cmd = CMD_STOP;
      S_ABORT: cmd = CMD_ABORT;
      default: is_cmd = 1'b0;
    endcase
  end

  assign cmd_valid_o = is_cmd && !pend_q;
  assign cmd_o       = cmd;
  assign cmd_bit_o   = cmd_bit;

  // shifter control
  always_comb begin
    sh_load  = 1'b0;
    sh_val   = '0;
    sh_shift = 1'b0;
    unique case (state_q)
      S_IDLE:  sh_load = req_valid_i && (req_len_i != '0) && req_nostart_i;
      S_START: begin sh_load = ok_fire; sh_val = abyte; end
      S_ABYTE, S_DBIT: sh_shift = ok_fire;
      S_AACK: begin
        sh_load = ok_fire && !rsp_bit_i;
        sh_val  = addr_last ? '0 : abyte;
      end
      S_DACK:  sh_load = ok_fire;
      S_LOAD:  begin sh_load = wr_valid_i; sh_val = wr_data_i; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pend_q     <= 1'b0;
      started_q  <= 1'b0;
      a_idx_q    <= 1'b0;
      left_q     <= '0;
      addr_q     <= '0;
      rd_q       <= 1'b0;
      ten_q      <= 1'b0;
      nostop_q   <= 1'b0;
      abort_st_q <= ST_OK;
      stat_q     <= ST_OK;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      if (cmd_valid_o) pend_q <= 1'b1;
      if (rsp_fire)    pend_q <= 1'b0;

      if (eng_err) begin
        state_q   <= S_IDLE;
        started_q <= 1'b0;
        done_q    <= 1'b1;
        stat_q    <= rsp_err_i[1] ? ST_ARBLOST : ST_TIMEOUT;
      end else begin
        unique case (state_q)
          S_IDLE: if (req_valid_i) begin
            if (req_len_i == '0) begin
              done_q <= 1'b1;
              stat_q <= ST_INVAL;
            end else begin
              addr_q   <= req_addr_i;
              rd_q     <= req_read_i;
              ten_q    <= req_addr10_i;
              nostop_q <= req_nostop_i;
              left_q   <= req_len_i;
              a_idx_q  <= 1'b0;
              if (!req_nostart_i)  state_q <= S_START;
              else if (req_read_i) state_q <= S_DBIT;
              else                 state_q <= S_LOAD;
            end
          end
          S_START: if (ok_fire) begin
            started_q <= 1'b1;
            state_q   <= S_ABYTE;
          end
          S_ABYTE: if (ok_fire && sh_last) state_q <= S_AACK;
          S_AACK: if (ok_fire) begin
            if (rsp_bit_i) begin
              abort_st_q <= ST_NODEV;
              state_q    <= S_ABORT;
            end else if (!addr_last) begin
              a_idx_q <= 1'b1;
              state_q <= S_ABYTE;
            end else begin
              state_q <= rd_q ? S_DBIT : S_LOAD;
            end
          end
          S_LOAD: if (wr_valid_i) state_q <= S_DBIT;
          S_DBIT: if (ok_fire && sh_last) begin
            state_q <= S_DACK;
            if (rd_q) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= {sh_data[BYTE_W-2:0], rsp_bit_i};
            end
          end
          S_DACK: if (ok_fire) begin
            if (!rd_q && rsp_bit_i) begin
              abort_st_q <= ST_IO;
              state_q    <= S_ABORT;
            end else begin
              left_q <= left_q - 1'b1;
              if (!last_byte) begin
                state_q <= rd_q ? S_DBIT : S_LOAD;
              end else if (nostop_q) begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
                stat_q  <= ST_OK;
              end else begin
                state_q <= S_STOP;
              end
            end
          end
          S_STOP: if (ok_fire) begin
            started_q <= 1'b0;
            state_q   <= S_IDLE;
            done_q    <= 1'b1;
            stat_q    <= ST_OK;
          end
          S_ABORT: if (rsp_fire) begin
            started_q <= 1'b0;
            state_q   <= S_IDLE;
            done_q    <= 1'b1;
            stat_q    <= abort_st_q;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign wr_ready_o  = (state_q == S_LOAD);
  assign rd_data_o   = rd_data_q;
  assign rd_valid_o  = rd_valid_q;
  assign done_o      = done_q;
  assign status_o    = stat_q;
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [LEN_W-1:0] req_len_i,
  input logic             wr_ready_o,
  input logic             rd_valid_o,
  input logic             done_o,
  input logic [2:0]       status_o,
  input logic             cmd_valid_o
);
  a_r12_single_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cmd_valid_o && !wr_ready_o));

  a_r2_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i == '0) |=> (done_o && status_o == 3'd3));

  a_r13_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_rd_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.LEN_W(LEN_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_len_i   (req_len_i),
  .wr_ready_o  (wr_ready_o),
  .rd_valid_o  (rd_valid_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .cmd_valid_o (cmd_valid_o)
);

// File: tb/i2c_txn_seq_tb_top.sv
module i2c_txn_seq_tb_top;
  localparam int LEN_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [9:0]       req_addr_i = '0;
  logic             req_read_i = 1'b0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic             req_addr10_i = 1'b0;
  logic             req_nostart_i = 1'b0;
  logic             req_nostop_i = 1'b0;
  logic [7:0]       wr_data_i;
  logic             wr_valid_i;
  logic             wr_ready_o;
  logic [7:0]       rd_data_o;
  logic             rd_valid_o;
  logic             done_o;
  logic [2:0]       status_o;
  logic             cmd_valid_o;
  logic [2:0]       cmd_o;
  logic             cmd_bit_o;
  logic             rsp_valid_i;
  logic             rsp_bit_i;
  logic [1:0]       rsp_err_i;

  i2c_txn_seq #(.LEN_W(LEN_W)) dut_i (.*);

  // bit engine model, write source, read sink
  logic [3:0] log_q  [0:255];
  logic [3:0] exp_q  [0:255];
  logic       rbits  [0:255];
  logic [7:0] wr_buf [0:15];
  logic [7:0] rd_buf [0:15];
  int log_n, rb_idx, wr_idx, rd_n, e_n, r_n;
  int err_at = -1;
  logic [1:0] err_code = 2'b00;
  logic clr = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  assign wr_valid_i = 1'b1;
  assign wr_data_i  = wr_buf[wr_idx[3:0]];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_i <= 1'b0; rsp_bit_i <= 1'b0; rsp_err_i <= 2'b00;
      log_n <= 0; rb_idx <= 0; wr_idx <= 0; rd_n <= 0;
    end else if (clr) begin
      rsp_valid_i <= 1'b0; rsp_bit_i <= 1'b0; rsp_err_i <= 2'b00;
      log_n <= 0; rb_idx <= 0; wr_idx <= 0; rd_n <= 0;
    end else begin
      rsp_valid_i <= 1'b0; rsp_bit_i <= 1'b0; rsp_err_i <= 2'b00;
      if (cmd_valid_o) begin
        log_q[log_n[7:0]] <= {cmd_o, cmd_bit_o};
        log_n <= log_n + 1;
        rsp_valid_i <= 1'b1;
        if (log_n == err_at) rsp_err_i <= err_code;
        if (cmd_o == 3'd3) begin
          rsp_bit_i <= rbits[rb_idx[7:0]];
          rb_idx <= rb_idx + 1;
        end
      end
      if (wr_ready_o && wr_valid_i) wr_idx <= wr_idx + 1;
      if (rd_valid_o) begin
        rd_buf[rd_n[3:0]] <= rd_data_o;
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk_i); clr = 1'b1;
    @(negedge clk_i); clr = 1'b0;
    e_n = 0; r_n = 0; err_at = -1; err_code = 2'b00;
  endtask

  task automatic e_push(input int c, input bit b);
    exp_q[e_n[7:0]] = {c[2:0], b};
    e_n++;
  endtask

  task automatic e_wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) e_push(2, v[i]);
  endtask

  task automatic e_rbyte();
    for (int i = 0; i < 8; i++) e_push(3, 1'b0);
  endtask

  task automatic r_push(input bit b);
    rbits[r_n[7:0]] = b;
    r_n++;
  endtask

  task automatic r_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) r_push(v[i]);
  endtask

  task automatic chk_log(input string r);
    bit ok;
    int bad;
    ok = (log_n == e_n);
    bad = -1;
    if (ok)
      for (int i = 0; i < e_n; i++)
        if (log_q[i] !== exp_q[i] && bad < 0) bad = i;
    if (bad >= 0) ok = 1'b0;
    chk(ok, r, (bad < 0) ? log_n : int'(log_q[bad]), (bad < 0) ? e_n : int'(exp_q[bad]));
  endtask

  task automatic run(input logic [9:0] a, input logic rd, input int len,
                     input logic t, input logic ns, input logic np, output logic [2:0] st);
    @(negedge clk_i);
    req_addr_i = a; req_read_i = rd; req_len_i = LEN_W'(len);
    req_addr10_i = t; req_nostart_i = ns; req_nostop_i = np; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    st = status_o;
    chk(req_ready_o == 1'b1, "R13 ready with done", req_ready_o, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R13 done pulse", done_o, 0);
  endtask

  task automatic t_reset();
    chk(req_ready_o == 1'b1 && cmd_valid_o == 1'b0 && wr_ready_o == 1'b0
        && rd_valid_o == 1'b0 && done_o == 1'b0, "R1 reset state",
        {req_ready_o, cmd_valid_o, wr_ready_o, rd_valid_o, done_o}, 5'b10000);
  endtask

  task automatic t_zero_len();
    logic [2:0] st;
    prep();
    run(10'h050, 1'b0, 0, 1'b0, 1'b0, 1'b0, st);
    chk(st == 3'd3, "R2 zero length status", st, 3);
    chk_log("R2 no bus activity");
  endtask

  task automatic t_write7();
    logic [2:0] st;
    prep();
    wr_buf[0] = 8'hA5; wr_buf[1] = 8'h3C;
    r_push(0); r_push(0); r_push(0);
    e_push(0, 0); e_wbyte(8'hA0); e_push(3, 0);
    e_wbyte(8'hA5); e_push(3, 0); e_wbyte(8'h3C); e_push(3, 0); e_push(1, 0);
    run(10'h050, 1'b0, 2, 1'b0, 1'b0, 1'b0, st);
    chk(st == 3'd0, "R7 write status", st, 0);
    chk_log("R3 R5 R7 write7 sequence");
    chk(wr_idx == 2, "R5 bytes taken", wr_idx, 2);
  endtask

  task automatic t_read7_nostop();
    logic [2:0] st;
    prep();
    r_push(0); r_byte(8'h96); r_byte(8'h5B);
    e_push(0, 0); e_wbyte(8'h37); e_push(3, 0);
    e_rbyte(); e_push(2, 0); e_rbyte(); e_push(2, 1);
    run(10'h01B, 1'b1, 2, 1'b0, 1'b0, 1'b1, st);
    chk(st == 3'd0, "R7 read status", st, 0);
    chk_log("R6 R7 read sequence, no stop");
    chk(rd_n == 2 && rd_buf[0] == 8'h96 && rd_buf[1] == 8'h5B, "R6 read data",
        {rd_buf[0], rd_buf[1]}, 16'h965B);
  endtask

  task automatic t_rep10_write();
    logic [2:0] st;
    prep();
    wr_buf[0] = 8'h81;
    r_push(0); r_push(0); r_push(0);
    e_push(0, 1); e_wbyte(8'hF4); e_push(3, 0); e_wbyte(8'hC5); e_push(3, 0);
    e_wbyte(8'h81); e_push(3, 0); e_push(1, 0);
    run(10'h2C5, 1'b0, 1, 1'b1, 1'b0, 1'b0, st);
    chk(st == 3'd0, "R4 status", st, 0);
    chk_log("R4 R9 repeated start 10-bit write");
  endtask

  task automatic t_nostart();
    logic [2:0] st;
    prep();
    wr_buf[0] = 8'h7E;
    r_push(0);
    e_wbyte(8'h7E); e_push(3, 0); e_push(1, 0);
    run(10'h050, 1'b0, 1, 1'b0, 1'b1, 1'b0, st);
    chk(st == 3'd0, "R8 status", st, 0);
    chk_log("R8 no start, no address");
  endtask

  task automatic t_read10();
    logic [2:0] st;
    prep();
    r_push(0); r_push(0); r_byte(8'hC3);
    e_push(0, 0); e_wbyte(8'hF7); e_push(3, 0); e_wbyte(8'hA2); e_push(3, 0);
    e_rbyte(); e_push(2, 1);
    run(10'h3A2, 1'b1, 1, 1'b1, 1'b0, 1'b1, st);
    chk(st == 3'd0 && rd_n == 1 && rd_buf[0] == 8'hC3, "R4 R6 10-bit read data",
        {st, rd_buf[0]}, 11'h0C3);
    chk_log("R4 10-bit read sequence");
  endtask

  task automatic t_addr_nack();
    logic [2:0] st;
    prep();
    wr_buf[0] = 8'h55;
    r_push(1);
    e_push(0, 1); e_wbyte(8'h44); e_push(3, 0); e_push(4, 0);
    run(10'h022, 1'b0, 2, 1'b0, 1'b0, 1'b0, st);
    chk(st == 3'd1, "R10 address nack status", st, 1);
    chk_log("R10 address nack abort");
    chk(wr_idx == 0, "R10 no byte taken", wr_idx, 0);
  endtask

  task automatic t_data_nack();
    logic [2:0] st;
    prep();
    wr_buf[0] = 8'h11; wr_buf[1] = 8'h22; wr_buf[2] = 8'h33;
    r_push(0); r_push(1);
    e_push(0, 0); e_wbyte(8'h44); e_push(3, 0); e_wbyte(8'h11); e_push(3, 0); e_push(4, 0);
    run(10'h022, 1'b0, 3, 1'b0, 1'b0, 1'b0, st);
    chk(st == 3'd2, "R10 data nack status", st, 2);
    chk_log("R9 R10 data nack after abort");
    chk(wr_idx == 1, "R10 one byte taken", wr_idx, 1);
  endtask

  task automatic t_err_arb();
    logic [2:0] st;
    prep();
    err_at = 0; err_code = 2'b10;
    e_push(0, 0);
    run(10'h010, 1'b0, 1, 1'b0, 1'b0, 1'b0, st);
    chk(st == 3'd5, "R11 arbitration lost status", st, 5);
    chk_log("R11 arbitration lost ends at once");
  endtask

  task automatic t_err_timeout();
    logic [2:0] st;
    prep();
    r_push(0);
    err_at = 3; err_code = 2'b01;
    e_push(0, 0); e_push(2, 0); e_push(2, 0); e_push(2, 1);
    run(10'h010, 1'b1, 1, 1'b0, 1'b0, 1'b1, st);
    chk(st == 3'd4, "R11 timeout status", st, 4);
    chk_log("R11 timeout ends at once");
  endtask

  task automatic t_after_err();
    logic [2:0] st;
    prep();
    wr_buf[0] = 8'h00;
    r_push(0); r_push(0);
    e_push(0, 0); e_wbyte(8'h20); e_push(3, 0); e_wbyte(8'h00); e_push(3, 0); e_push(1, 0);
    run(10'h010, 1'b0, 1, 1'b0, 1'b0, 1'b0, st);
    chk(st == 3'd0, "R9 status after error", st, 0);
    chk_log("R9 plain start after engine error");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_zero_len();
    t_write7();
    t_read7_nostop();
    t_rep10_write();
    t_nostart();
    t_read10();
    t_addr_nack();
    t_data_nack();
    t_err_arb();
    t_err_timeout();
    t_after_err();
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule